// File: doc/BRIEF.md
# Dual Stack-Operation Sequencer

This block executes packed stack instructions. One 16-bit word carries two independent stack operations in two 6-bit slots. The block runs the upper slot to completion and then the lower slot. It works on an external top-of-stack port, which supplies the top word and the word beneath it, and accepts pop and push commands. The block keeps a condition code that compare operations write. It pulses `done` once the word has been fully handled.

The supported operations are empty slot, add, compare, divide and delete. Division is iterative, so a word that holds a divide takes several cycles longer than one that does not. A zero divisor and an unknown code both end the word early with a sticky flag. Any part of the word that already ran stays in effect.

Top module: `dual_stackop_seq`

## Requirements
- R1: A `start` pulse while idle latches `instr`. The upper slot (bits 11-6) executes before the lower slot (bits 5-0). `busy` goes high from the cycle after `start` until `done` inclusive, and `done` is a one-cycle pulse after the last action.
- R2: Slot codes are 0 for an empty slot, 1 for add, 2 for compare, 3 for divide and 4 for delete. An empty slot changes neither the stack nor the condition code.
- R3: Add removes the top two words and pushes their sum modulo 2^16.
- R4: Compare removes the top two words and pushes nothing. It sets `cc` from a signed comparison of the lower word (TOS-1) against the top word (TOS): 2'b01 below, 2'b00 equal, 2'b10 above. No other `cc` value appears.
- R5: Divide treats TOS-1 as an unsigned dividend and TOS as an unsigned divisor, and removes both. It pushes the quotient and then the remainder, so the remainder ends on top.
- R6: Delete removes the top word.
- R7: A divide with a zero divisor sets `div_trap`, leaves the stack as it was before that slot, skips any later slot and still ends with `done`. `div_trap` and `illegal` are never high together.
- R8: A word whose bits 15-12 are not 0000, or a slot code from 5 to 63, sets `illegal` and stops the word with `done`. A faulty lower slot keeps the upper slot's effect. A word rejected for its top bits changes nothing.
- R9: After reset `busy`, `done`, `div_trap` and `illegal` are low and `cc` is 2'b00. Flags clear when the next `start` is accepted. `cc` keeps its value until a compare writes it, including across words.
- R10: `start` is ignored while `busy` is high.
- R11: At most two words are popped per cycle (`stk_pop` is 0, 1 or 2). A push in the same cycle lands on the stack after the pops. No stack command is issued while idle or while a flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing `instr` |
| instr | input | 16 | Packed instruction word |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| cc | output | 2 | Condition code: 00 equal, 01 below, 10 above |
| div_trap | output | 1 | Sticky zero-divisor flag |
| illegal | output | 1 | Sticky bad-encoding flag |
| stk_tos | input | 16 | Current top of stack |
| stk_nos | input | 16 | Word beneath the top |
| stk_pop | output | 2 | Number of words to pop this cycle |
| stk_push | output | 1 | Push `stk_wdata` this cycle, after the pops |
| stk_wdata | output | 16 | Data to push |

## Verification
The bench targets the add wrap at 0xFFFF + 3. A sequencer that kept a carry would leave the wrong top. Compare uses -1 against 1, where an unsigned comparison would report "above" in place of "below". Divide uses 0xFFFF / 16 and chained divides: pushing the two results in the wrong order swaps quotient and remainder, and a restoring-step error corrupts the quotient's top bits. Faults placed in the upper slot and in the lower slot, together with a start pulse sent mid-divide, expose a design that runs past a trap, undoes work already done, leaves flags stuck, or restarts on a second start.

// File: rtl/stackop_pkg.sv
// Shared types for the dual stack-operation sequencer.
// Assumes slot codes are small unsigned integers; anything undecoded maps to SK_BAD.
package stackop_pkg;

    localparam int unsigned CODE_NOP = 0;
    localparam int unsigned CODE_ADD = 1;
    localparam int unsigned CODE_CMP = 2;
    localparam int unsigned CODE_DIV = 3;
    localparam int unsigned CODE_DEL = 4;

    typedef enum logic [2:0] {
        SK_NOP,
        SK_ADD,
        SK_CMP,
        SK_DIV,
        SK_DEL,
        SK_BAD
    } slot_kind_e;

    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10
    } cond_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_DIVWAIT,
        ST_ISSUE,
        ST_PUSHREM,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/stackop_slot_dec.sv
// Decodes one operation slot into a kind.
// Purely combinational; assumes the caller selects which slot runs.
module stackop_slot_dec
    import stackop_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic [SLOT_W-1:0] code,
    output slot_kind_e        kind
);

    // Map numeric slot code to operation kind.
    always_comb begin
        if      (code == SLOT_W'(CODE_NOP)) kind = SK_NOP;
        else if (code == SLOT_W'(CODE_ADD)) kind = SK_ADD;
        else if (code == SLOT_W'(CODE_CMP)) kind = SK_CMP;
        else if (code == SLOT_W'(CODE_DIV)) kind = SK_DIV;
        else if (code == SLOT_W'(CODE_DEL)) kind = SK_DEL;
        else                                kind = SK_BAD;
    end

endmodule

// File: rtl/stackop_alu.sv
// Single-cycle arithmetic for the sequencer: modular sum and signed compare.
// Assumes lower = TOS-1 and upper = TOS; compare is lower against upper.
module stackop_alu
    import stackop_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] lower,
    input  logic [WORD_W-1:0] upper,
    output logic [WORD_W-1:0] sum,
    output logic [1:0]        cmp_cc
);

    // Sum wraps to the word width.
    always_comb sum = lower + upper;

    // Signed three-way comparison.
    always_comb begin
        if ($signed(lower) < $signed(upper))      cmp_cc = CC_LT;
        else if ($signed(lower) > $signed(upper)) cmp_cc = CC_GT;
        else                                      cmp_cc = CC_EQ;
    end

endmodule

// File: rtl/stackop_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes the divisor is nonzero (the caller traps zero); results hold until the next go.
module stackop_divider #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] dividend,
    input  logic [WORD_W-1:0] divisor,
    output logic              fin,
    output logic [WORD_W-1:0] quotient,
    output logic [WORD_W-1:0] remainder
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W:0]   part_q;
    logic [WORD_W-1:0] quo_q;
    logic [WORD_W-1:0] dvs_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W:0]   shifted;
    logic [WORD_W:0]   trial;

    // Next partial remainder candidate for this step.
    always_comb begin
        shifted = {part_q[WORD_W-1:0], quo_q[WORD_W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    // Iterate one bit per cycle, flag the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                part_q <= '0;
                quo_q  <= dividend;
                dvs_q  <= divisor;
                cnt_q  <= CNT_W'(WORD_W);
            end else if (cnt_q != '0) begin
                if (!trial[WORD_W]) begin
                    part_q <= trial;
                    quo_q  <= {quo_q[WORD_W-2:0], 1'b1};
                end else begin
                    part_q <= shifted;
                    quo_q  <= {quo_q[WORD_W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                fin   <= (cnt_q == CNT_W'(1));
            end
        end
    end

    assign quotient  = quo_q;
    assign remainder = part_q[WORD_W-1:0];

endmodule

// File: rtl/dual_stackop_seq.sv
// Sequencer for packed stack words holding two operation slots.
// Runs the upper slot, then the lower one, against an external top-of-stack port.
// Assumes the stack holds enough words for every operation it is asked to run.
module dual_stackop_seq
    import stackop_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int OPC_W  = 4,
    parameter int SLOT_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [OPC_W+2*SLOT_W-1:0]       instr,
    output logic                            busy,
    output logic                            done,
    output logic [1:0]                      cc,
    output logic                            div_trap,
    output logic                            illegal,
    input  logic [WORD_W-1:0]               stk_tos,
    input  logic [WORD_W-1:0]               stk_nos,
    output logic [1:0]                      stk_pop,
    output logic                            stk_push,
    output logic [WORD_W-1:0]               stk_wdata
);

    localparam int INSTR_W = OPC_W + 2 * SLOT_W;
    localparam int N_SLOTS = 2;

    seq_state_e            state_q, state_d;
    logic [INSTR_W-1:0]    instr_q;
    logic                  slot_q;
    slot_kind_e            kind_q;
    logic [WORD_W-1:0]     lower_q, upper_q;
    logic [1:0]            cc_q;
    logic                  trap_q, ill_q;
    slot_kind_e            slot_kind [N_SLOTS];
    slot_kind_e            cur_kind;
    logic                  word_ok;
    logic                  div_go, div_fin;
    logic [WORD_W-1:0]     div_quo, div_rem;
    logic [WORD_W-1:0]     alu_sum;
    logic [1:0]            alu_cc;

    // One decoder per slot; slot 0 is the upper (first-run) field.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        stackop_slot_dec #(.SLOT_W(SLOT_W)) u_dec (
            .code (instr_q[INSTR_W-OPC_W-1-s*SLOT_W -: SLOT_W]),
            .kind (slot_kind[s])
        );
    end

    stackop_alu #(.WORD_W(WORD_W)) u_alu (
        .lower  (lower_q),
        .upper  (upper_q),
        .sum    (alu_sum),
        .cmp_cc (alu_cc)
    );

    stackop_divider #(.WORD_W(WORD_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (div_go),
        .dividend  (stk_nos),
        .divisor   (stk_tos),
        .fin       (div_fin),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    // Select the slot under execution and check the stack-word prefix.
    always_comb begin
        cur_kind = slot_q ? slot_kind[1] : slot_kind[0];
        word_ok  = (instr_q[INSTR_W-1 -: OPC_W] == '0);
        div_go   = (state_q == ST_DECODE) && word_ok &&
                   (cur_kind == SK_DIV) && (stk_tos != '0);
    end

    // Next-state logic of the sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_DECODE;
            ST_DECODE: begin
                if (!word_ok) state_d = ST_DONE;
                else begin
                    unique case (cur_kind)
                        SK_NOP:  state_d = slot_q ? ST_DONE : ST_DECODE;
                        SK_BAD:  state_d = ST_DONE;
                        SK_DIV:  state_d = (stk_tos == '0) ? ST_DONE : ST_DIVWAIT;
                        default: state_d = ST_ISSUE;
                    endcase
                end
            end
            ST_DIVWAIT: if (div_fin) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (kind_q == SK_DIV) state_d = ST_PUSHREM;
                else                  state_d = slot_q ? ST_DONE : ST_DECODE;
            end
            ST_PUSHREM: state_d = slot_q ? ST_DONE : ST_DECODE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State, latched word, operands, slot pointer, flags and condition code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            instr_q <= '0;
            slot_q  <= 1'b0;
            kind_q  <= SK_NOP;
            lower_q <= '0;
            upper_q <= '0;
            cc_q    <= CC_EQ;
            trap_q  <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    instr_q <= instr;
                    slot_q  <= 1'b0;
                    trap_q  <= 1'b0;
                    ill_q   <= 1'b0;
                end
                ST_DECODE: begin
                    kind_q  <= cur_kind;
                    lower_q <= stk_nos;
                    upper_q <= stk_tos;
                    if (!word_ok || cur_kind == SK_BAD) ill_q <= 1'b1;
                    else if (cur_kind == SK_DIV && stk_tos == '0) trap_q <= 1'b1;
                    else if (cur_kind == SK_NOP) slot_q <= 1'b1;
                end
                ST_ISSUE: begin
                    if (kind_q == SK_CMP) cc_q <= alu_cc;
                    if (kind_q != SK_DIV) slot_q <= 1'b1;
                end
                ST_PUSHREM: slot_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Stack commands issued by the current state.
    always_comb begin
        stk_pop   = 2'd0;
        stk_push  = 1'b0;
        stk_wdata = '0;
        if (state_q == ST_ISSUE) begin
            unique case (kind_q)
                SK_ADD: begin stk_pop = 2'd2; stk_push = 1'b1; stk_wdata = alu_sum; end
                SK_CMP: stk_pop = 2'd2;
                SK_DEL: stk_pop = 2'd1;
                SK_DIV: begin stk_pop = 2'd2; stk_push = 1'b1; stk_wdata = div_quo; end
                default: ;
            endcase
        end else if (state_q == ST_PUSHREM) begin
            stk_push  = 1'b1;
            stk_wdata = div_rem;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign cc       = cc_q;
    assign div_trap = trap_q;
    assign illegal  = ill_q;

endmodule

// File: rtl/dual_stackop_seq_chk.sv
// Property checker for the dual stack-operation sequencer, bound to the top.
// Observes ports only; assumes synchronous active-low reset.
module dual_stackop_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] cc,
    input logic       div_trap,
    input logic       illegal,
    input logic [1:0] stk_pop,
    input logic       stk_push
);

    AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R1
    AST_DONE_IN_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R1
    AST_CC_LEGAL:      assert property (@(posedge clk) disable iff (!rst_n) cc != 2'b11); // R4
    AST_TRAP_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) div_trap |-> (stk_pop == 2'd0 && !stk_push)); // R7
    AST_FLAGS_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(div_trap && illegal)); // R7
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> (stk_pop == 2'd0 && !stk_push)); // R8
    AST_CC_HOLD_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(cc)); // R9
    AST_BUSY_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R10
    AST_POP_LIMIT:     assert property (@(posedge clk) disable iff (!rst_n) stk_pop != 2'd3); // R11
    AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (stk_pop == 2'd0 && !stk_push)); // R11

endmodule

bind dual_stackop_seq dual_stackop_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .cc       (cc),
    .div_trap (div_trap),
    .illegal  (illegal),
    .stk_pop  (stk_pop),
    .stk_push (stk_push)
);

// File: tb/sim_dual_stackop_seq.sv
// Self-checking bench: vector table walk, then directed reset and corner tests.
module sim_dual_stackop_seq;

    localparam logic [5:0] S_NOP = 6'd0, S_ADD = 6'd1, S_CMP = 6'd2,
                           S_DIV = 6'd3, S_DEL = 6'd4;

    typedef struct packed {
        logic [15:0] ins;
        logic [15:0] v0, v1, v2, v3;
        logic [3:0]  dep;
        logic [15:0] top, nos;
        logic [1:0]  ecc;
        logic        trap, ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{{4'h0,S_ADD,S_NOP}, 16'd10,16'd20,16'd30,16'd40, 4'd3, 16'd70,16'd20, 2'b00,1'b0,1'b0, 4'd3}, // R3 R2
        '{{4'h0,S_ADD,S_ADD}, 16'd1,16'd2,16'd3,16'd4,     4'd2, 16'd9,16'd1,   2'b00,1'b0,1'b0, 4'd1}, // R1 R3
        '{{4'h0,S_NOP,S_ADD}, 16'd0,16'd0,16'hFFFF,16'd3,  4'd3, 16'd2,16'd0,   2'b00,1'b0,1'b0, 4'd3}, // R3 wrap
        '{{4'h0,S_CMP,S_NOP}, 16'd0,16'd0,16'd5,16'd3,     4'd2, 16'd0,16'd0,   2'b10,1'b0,1'b0, 4'd4}, // R4 above
        '{{4'h0,S_CMP,S_NOP}, 16'd0,16'd0,16'hFFFF,16'd1,  4'd2, 16'd0,16'd0,   2'b01,1'b0,1'b0, 4'd4}, // R4 signed
        '{{4'h0,S_CMP,S_DEL}, 16'd7,16'd8,16'd9,16'd9,     4'd1, 16'd7,16'd0,   2'b00,1'b0,1'b0, 4'd6}, // R4 R6
        '{{4'h0,S_DIV,S_NOP}, 16'd0,16'd0,16'd17,16'd5,    4'd4, 16'd2,16'd3,   2'b00,1'b0,1'b0, 4'd5}, // R5
        '{{4'h0,S_DIV,S_DIV}, 16'd0,16'd1000,16'd50,16'd7, 4'd4, 16'd0,16'd7,   2'b00,1'b0,1'b0, 4'd5}, // R5 chain
        '{{4'h0,S_DIV,S_NOP}, 16'd0,16'd0,16'hFFFF,16'd16, 4'd4, 16'h000F,16'h0FFF, 2'b00,1'b0,1'b0, 4'd5}, // R5 unsigned
        '{{4'h0,S_DIV,S_ADD}, 16'd1,16'd2,16'd3,16'd0,     4'd4, 16'd0,16'd3,   2'b00,1'b1,1'b0, 4'd7}, // R7 upper
        '{{4'h0,S_ADD,S_DIV}, 16'd1,16'd2,16'd0,16'd0,     4'd3, 16'd0,16'd2,   2'b00,1'b1,1'b0, 4'd7}, // R7 lower
        '{{4'h0,6'd5,S_ADD},  16'd1,16'd2,16'd3,16'd4,     4'd4, 16'd4,16'd3,   2'b00,1'b0,1'b1, 4'd8}, // R8 R9 clear
        '{{4'h0,S_ADD,6'd63}, 16'd1,16'd2,16'd3,16'd4,     4'd3, 16'd7,16'd2,   2'b00,1'b0,1'b1, 4'd8}, // R8 lower
        '{{4'h1,S_ADD,S_NOP}, 16'd1,16'd2,16'd3,16'd4,     4'd4, 16'd4,16'd3,   2'b00,1'b0,1'b1, 4'd8}, // R8 prefix
        '{{4'h0,S_DEL,S_DEL}, 16'd1,16'd2,16'd3,16'd4,     4'd2, 16'd2,16'd1,   2'b00,1'b0,1'b0, 4'd6}, // R6
        '{{4'h0,S_NOP,S_NOP}, 16'd1,16'd2,16'd3,16'd4,     4'd4, 16'd4,16'd3,   2'b00,1'b0,1'b0, 4'd2}, // R2
        '{{4'h0,S_CMP,S_CMP}, 16'd3,16'd1,16'd2,16'd9,     4'd0, 16'd0,16'd0,   2'b10,1'b0,1'b0, 4'd4}, // R4 order
        '{{4'h0,S_DIV,S_DEL}, 16'd0,16'd0,16'd9,16'd4,     4'd3, 16'd2,16'd0,   2'b10,1'b0,1'b0, 4'd9}  // R9 cc hold
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        busy, done, div_trap, illegal, stk_push;
    logic [1:0]  cc, stk_pop;
    logic [15:0] stk_tos, stk_nos, stk_wdata;

    logic        ld = 1'b0;
    logic [15:0] ldv [4];
    logic [15:0] smem [16];
    int          sp = 0;
    int          n_chk = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    dual_stackop_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .done(done), .cc(cc), .div_trap(div_trap), .illegal(illegal),
        .stk_tos(stk_tos), .stk_nos(stk_nos), .stk_pop(stk_pop),
        .stk_push(stk_push), .stk_wdata(stk_wdata)
    );

    // Behavioural stack: preload on request, else apply pops then push.
    always @(posedge clk) begin
        int np;
        if (ld) begin
            for (int i = 0; i < 4; i++) smem[i] <= ldv[i];
            sp <= 4;
        end else begin
            np = sp - int'(stk_pop);
            if (np < 0) np = 0;
            if (stk_push && np < 16) begin
                smem[np] <= stk_wdata;
                sp <= np + 1;
            end else begin
                sp <= np;
            end
        end
    end

    assign stk_tos = (sp >= 1) ? smem[sp-1] : 16'd0;
    assign stk_nos = (sp >= 2) ? smem[sp-2] : 16'd0;

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog R1: actual cycle %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [15:0] a, b, c, d);
        @(negedge clk);
        ldv[0] = a; ldv[1] = b; ldv[2] = c; ldv[3] = d;
        ld = 1'b1;
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic run_word(input logic [15:0] w);
        int t;
        @(negedge clk);
        instr = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(done == 1'b1, "R1", "done seen", {31'd0, done}, 32'd1);
    endtask

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(busy == 1'b0 && done == 1'b0, "R9", "busy/done after reset", {30'd0, busy, done}, 32'd0);
        check(cc == 2'b00, "R9", "cc after reset", {30'd0, cc}, 32'd0);
        check(!div_trap && !illegal, "R9", "flags after reset", {30'd0, div_trap, illegal}, 32'd0);
        check(stk_pop == 2'd0 && !stk_push, "R11", "idle stack cmds", {29'd0, stk_pop, stk_push}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            preload(VECS[k].v0, VECS[k].v1, VECS[k].v2, VECS[k].v3);
            run_word(VECS[k].ins);
            @(negedge clk);
            tag = $sformatf("R%0d v%0d", VECS[k].req, k);
            check(sp == int'(VECS[k].dep), tag, "depth", sp, {28'd0, VECS[k].dep});
            if (VECS[k].dep >= 1)
                check(stk_tos == VECS[k].top, tag, "top", {16'd0, stk_tos}, {16'd0, VECS[k].top});
            if (VECS[k].dep >= 2)
                check(stk_nos == VECS[k].nos, tag, "next", {16'd0, stk_nos}, {16'd0, VECS[k].nos});
            check(cc == VECS[k].ecc, tag, "cc", {30'd0, cc}, {30'd0, VECS[k].ecc});
            check(div_trap == VECS[k].trap, tag, "div_trap", {31'd0, div_trap}, {31'd0, VECS[k].trap});
            check(illegal == VECS[k].ill, tag, "illegal", {31'd0, illegal}, {31'd0, VECS[k].ill});
            check(busy == 1'b0, tag, "idle after done", {31'd0, busy}, 32'd0);
        end

        // R10: second start mid-divide is ignored
        preload(16'd0, 16'd0, 16'd23, 16'd4);
        @(negedge clk);
        instr = {4'h0, S_DIV, S_NOP};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b1, "R10", "busy mid-divide", {31'd0, busy}, 32'd1);
        instr = {4'h0, S_DEL, S_DEL};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sp == 4, "R10", "depth after ignored start", sp, 32'd4);
        check(stk_tos == 16'd3 && stk_nos == 16'd5, "R10", "divide result",
              {stk_nos, stk_tos}, {16'd5, 16'd3});
        check(busy == 1'b0, "R10", "no restart", {31'd0, busy}, 32'd0);

        // R9: reset mid-word returns to the reset state
        preload(16'd0, 16'd0, 16'd5, 16'd0);
        run_word({4'h0, S_DIV, S_NOP});
        check(div_trap == 1'b1, "R7", "trap before reset", {31'd0, div_trap}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!div_trap && !busy && cc == 2'b00, "R9", "state after second reset",
              {29'd0, div_trap, busy, cc}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule